// File: doc/BRIEF.md
# Channel Start Scheduler for a Multi-Channel Transfer Engine

This block decides, for a bank of up to sixteen transfer channels, which channel the transfer engine runs next and when. Each channel keeps its own request gate, a trigger-source selection with an enable, a priority level, completion status (done, error, interrupt) and two chaining links. A channel becomes a candidate for three reasons. A hardware request line that it selects may be asserted. Software may order a single start. Another channel may finish a minor loop, or its whole major loop, and name this channel as its follower.

Software controls the block by writing a channel number together with an operation code: grant or withdraw the hardware request gate, start once, or clear the interrupt, done or error bit. When the engine is idle, the scheduler picks the winning candidate and emits a one-cycle start pulse with the channel number. It then waits for the engine to report the end of that minor loop, which is flagged as final or errored when applicable. Only one channel is ever in flight. The data movement itself happens in the engine, outside this block.

Top module: `chan_start_ctl`

## Requirements
- R1: After reset no channel is active, no start pulse is issued, and every request gate, done, error and interrupt bit reads zero.
- R2: A hardware request starts a channel only while its trigger enable and its request gate are both set and its selected line `hw_req[src]` is high. Command op 0 with a channel number sets that channel's gate and op 1 clears it.
- R3: Source numbers at or above ALWAYS_BASE (default 60) count as permanently asserted. A channel gated onto one restarts on the second cycle after each minor loop ends.
- R4: Command op 2 starts the named channel exactly once, whatever the state of its request gate.
- R5: When a channel's minor loop ends without the final flag and without error, and its minor link is enabled, the linked channel is started. After the final iteration the minor link does nothing.
- R6: When a channel's final minor loop ends without error, that channel's done and interrupt bits are set. If its major link is enabled, the major-linked channel is started.
- R7: Among candidates the channel with the greatest priority level wins, and equal levels go to the higher channel number. After reset each channel's level equals its own number, so the highest-numbered channel wins.
- R8: A start that arrives for any channel while another channel is active, or while that same channel is active, is kept. It is serviced after the active minor loop ends.
- R9: Op 3 clears the named channel's interrupt bit, op 4 its done bit and op 5 its error bit. A loop that ends with the error flag sets the error bit, leaves done unchanged and triggers no link.
- R10: A trigger configuration write that keeps the enable set and names a different source, while the channel's enable is already set, is ignored. To change source, software first writes the enable to zero.
- R11: `start_valid` is high for single cycles only, always together with `busy`. The start that follows the end of a minor loop is issued no earlier than the second cycle after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_op | input | 3 | Operation: 0 set gate, 1 clear gate, 2 start, 3 clear irq, 4 clear done, 5 clear error |
| cmd_ch | input | CH_W | Channel the command applies to |
| cfg_we | input | 1 | Trigger configuration write strobe |
| cfg_ch | input | CH_W | Channel being configured |
| cfg_src | input | SRC_W | Request source number |
| cfg_en | input | 1 | Trigger enable |
| link_we | input | 1 | Link configuration write strobe |
| link_ch | input | CH_W | Channel whose links are written |
| link_minor_en | input | 1 | Enable minor-loop link |
| link_minor_to | input | CH_W | Minor-link target channel |
| link_major_en | input | 1 | Enable major-loop link |
| link_major_to | input | CH_W | Major-link target channel |
| prio_we | input | 1 | Priority write strobe |
| prio_ch | input | CH_W | Channel whose level is written |
| prio_lvl | input | CH_W | New priority level |
| hw_req | input | 2**SRC_W | Hardware request lines |
| eng_done | input | 1 | Engine finished the active minor loop |
| eng_last | input | 1 | That minor loop was the final iteration |
| eng_err | input | 1 | That minor loop ended in error |
| start_valid | output | 1 | One-cycle start pulse to the engine |
| start_ch | output | CH_W | Channel started / currently active |
| busy | output | 1 | A channel is active |
| req_en_vec | output | NCH | Request gate per channel |
| done_vec | output | NCH | Done bit per channel |
| err_vec | output | NCH | Error bit per channel |
| irq_vec | output | NCH | Interrupt bit per channel |

## Verification
Two functions can fall in the same cycle: a new start can arrive for a channel in the very cycle the arbiter grants that channel, and a link start and a software start can target one channel at once. The random phase fires start commands in every cycle with 30% probability, against random priority levels and random engine completion times. Many of these commands therefore land on a grant edge. A bench model that keeps the newly arrived start pending judges the next winner and the exact cycle of every start pulse. Directed cases cover gating, always-on sources, the final-iteration rule of minor links, and the locked source change.

// File: rtl/chan_ctl_pkg.sv
`timescale 1ns/1ps
package chan_ctl_pkg;

   typedef enum logic [2:0] {
      OP_SETREQ  = 3'd0,
      OP_CLRREQ  = 3'd1,
      OP_START   = 3'd2,
      OP_CLRIRQ  = 3'd3,
      OP_CLRDONE = 3'd4,
      OP_CLRERR  = 3'd5
   } cmd_op_e;

endpackage

// File: rtl/chan_slot.sv
`timescale 1ns/1ps
module chan_slot
   import chan_ctl_pkg::*;
#(
   parameter int NCH         = 16,
   parameter int SRC_W       = 6,
   parameter int ALWAYS_BASE = 60,
   parameter int IDX         = 0,
   localparam int CH_W       = $clog2(NCH),
   localparam int NSRC       = 1 << SRC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [2:0]       cmd_op,
   input  logic [CH_W-1:0]  cmd_ch,
   input  logic             cfg_we,
   input  logic [CH_W-1:0]  cfg_ch,
   input  logic [SRC_W-1:0] cfg_src,
   input  logic             cfg_en,
   input  logic             link_we,
   input  logic [CH_W-1:0]  link_ch,
   input  logic             link_minor_en,
   input  logic [CH_W-1:0]  link_minor_to,
   input  logic             link_major_en,
   input  logic [CH_W-1:0]  link_major_to,
   input  logic             prio_we,
   input  logic [CH_W-1:0]  prio_ch,
   input  logic [CH_W-1:0]  prio_lvl,
   input  logic [NSRC-1:0]  hw_req,
   input  logic             grant_me,
   input  logic             fin_me,
   input  logic             fin_last,
   input  logic             fin_err,
   input  logic             link_hit,
   output logic             eligible,
   output logic [CH_W-1:0]  lvl,
   output logic             minor_en,
   output logic [CH_W-1:0]  minor_to,
   output logic             major_en,
   output logic [CH_W-1:0]  major_to,
   output logic             req_en,
   output logic             done,
   output logic             err,
   output logic             irq
);

   localparam logic [CH_W-1:0] ME = CH_W'(IDX);

   logic             req_en_q, trig_en_q, pend_q;
   logic [SRC_W-1:0] src_q;
   logic             irq_q, done_q, err_q;
   logic             mn_en_q, mj_en_q;
   logic [CH_W-1:0]  mn_to_q, mj_to_q, lvl_q;
   logic             line;

   logic cmd_me, cfg_me, sw_start, clr_irq, clr_done, clr_err, set_cpl, set_err, cfg_ok;

   assign cmd_me   = cmd_valid && (cmd_ch == ME);
   assign cfg_me   = cfg_we && (cfg_ch == ME);
   assign sw_start = cmd_me && (cmd_op == OP_START);
   assign clr_irq  = cmd_me && (cmd_op == OP_CLRIRQ);
   assign clr_done = cmd_me && (cmd_op == OP_CLRDONE);
   assign clr_err  = cmd_me && (cmd_op == OP_CLRERR);
   assign set_cpl  = fin_me && fin_last && !fin_err;
   assign set_err  = fin_me && fin_err;
   // source may only move while the trigger is off, or when the write turns it off
   assign cfg_ok   = !trig_en_q || !cfg_en || (cfg_src == src_q);

   generate
      if (ALWAYS_BASE < NSRC) begin : g_always
         assign line = hw_req[src_q] || (int'(src_q) >= ALWAYS_BASE);
      end else begin : g_plain
         assign line = hw_req[src_q];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_en_q  <= 1'b0;
         trig_en_q <= 1'b0;
         src_q     <= '0;
         pend_q    <= 1'b0;
         irq_q     <= 1'b0;
         done_q    <= 1'b0;
         err_q     <= 1'b0;
         mn_en_q   <= 1'b0;
         mj_en_q   <= 1'b0;
         mn_to_q   <= '0;
         mj_to_q   <= '0;
         lvl_q     <= ME;
      end else begin
         if (cmd_me && (cmd_op == OP_SETREQ)) req_en_q <= 1'b1;
         else if (cmd_me && (cmd_op == OP_CLRREQ)) req_en_q <= 1'b0;

         pend_q <= (pend_q && !grant_me) || sw_start || link_hit;

         if (cfg_me && cfg_ok) begin
            src_q     <= cfg_src;
            trig_en_q <= cfg_en;
         end

         if (link_we && (link_ch == ME)) begin
            mn_en_q <= link_minor_en;
            mn_to_q <= link_minor_to;
            mj_en_q <= link_major_en;
            mj_to_q <= link_major_to;
         end

         if (prio_we && (prio_ch == ME)) lvl_q <= prio_lvl;

         if (set_cpl)       irq_q <= 1'b1;
         else if (clr_irq)  irq_q <= 1'b0;
         if (set_cpl)       done_q <= 1'b1;
         else if (clr_done) done_q <= 1'b0;
         if (set_err)       err_q <= 1'b1;
         else if (clr_err)  err_q <= 1'b0;
      end
   end

   assign eligible = pend_q || (trig_en_q && req_en_q && line);
   assign lvl      = lvl_q;
   assign minor_en = mn_en_q;
   assign minor_to = mn_to_q;
   assign major_en = mj_en_q;
   assign major_to = mj_to_q;
   assign req_en   = req_en_q;
   assign done     = done_q;
   assign err      = err_q;
   assign irq      = irq_q;

   // R9
   irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_irq && !set_cpl) |=> !irq_q);

   // R10
   cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_me && trig_en_q && cfg_en && (cfg_src != src_q)) |=> $stable(src_q));

   // R2
   gate_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_me && (cmd_op == OP_CLRREQ)) |=> !req_en_q);

endmodule

// File: rtl/prio_pick.sv
`timescale 1ns/1ps
module prio_pick #(
   parameter int NCH   = 16,
   localparam int CH_W = $clog2(NCH),
   localparam int KEY_W = 2 * CH_W
) (
   input  logic [NCH-1:0]           elig,
   input  logic [NCH-1:0][CH_W-1:0] lvl,
   output logic                     any,
   output logic [CH_W-1:0]          win
);

   logic [KEY_W-1:0] best;

   always_comb begin
      any  = 1'b0;
      win  = '0;
      best = '0;
      for (int c = 0; c < NCH; c++) begin
         if (elig[c] && (!any || ({lvl[c], CH_W'(c)} > best))) begin
            any  = 1'b1;
            best = {lvl[c], CH_W'(c)};
            win  = CH_W'(c);
         end
      end
   end

endmodule

// File: rtl/chan_start_ctl.sv
`timescale 1ns/1ps
module chan_start_ctl
   import chan_ctl_pkg::*;
#(
   parameter int NCH         = 16,
   parameter int SRC_W       = 6,
   parameter int ALWAYS_BASE = 60,
   localparam int CH_W       = $clog2(NCH),
   localparam int NSRC       = 1 << SRC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [2:0]       cmd_op,
   input  logic [CH_W-1:0]  cmd_ch,
   input  logic             cfg_we,
   input  logic [CH_W-1:0]  cfg_ch,
   input  logic [SRC_W-1:0] cfg_src,
   input  logic             cfg_en,
   input  logic             link_we,
   input  logic [CH_W-1:0]  link_ch,
   input  logic             link_minor_en,
   input  logic [CH_W-1:0]  link_minor_to,
   input  logic             link_major_en,
   input  logic [CH_W-1:0]  link_major_to,
   input  logic             prio_we,
   input  logic [CH_W-1:0]  prio_ch,
   input  logic [CH_W-1:0]  prio_lvl,
   input  logic [NSRC-1:0]  hw_req,
   input  logic             eng_done,
   input  logic             eng_last,
   input  logic             eng_err,
   output logic             start_valid,
   output logic [CH_W-1:0]  start_ch,
   output logic             busy,
   output logic [NCH-1:0]   req_en_vec,
   output logic [NCH-1:0]   done_vec,
   output logic [NCH-1:0]   err_vec,
   output logic [NCH-1:0]   irq_vec
);

   generate
      if (NCH < 2 || NCH > 64) begin : g_bad_nch
         $error("NCH must lie in 2..64");
      end
      if (SRC_W < 1 || SRC_W > 8) begin : g_bad_src
         $error("SRC_W must lie in 1..8");
      end
      if (ALWAYS_BASE < 0 || ALWAYS_BASE > NSRC) begin : g_bad_base
         $error("ALWAYS_BASE must lie in 0..2**SRC_W");
      end
   endgenerate

   logic                     busy_q, start_valid_q;
   logic [CH_W-1:0]          start_ch_q;
   logic [NCH-1:0]           elig_vec;
   logic [NCH-1:0][CH_W-1:0] lvl_arr;
   logic [NCH-1:0]           mn_en_v, mj_en_v;
   logic [NCH-1:0][CH_W-1:0] mn_to_a, mj_to_a;
   logic                     win_valid, grant, fin, tgt_valid;
   logic [CH_W-1:0]          win_ch, tgt;

   assign grant = !busy_q && win_valid;
   assign fin   = busy_q && eng_done;

   // follower selection: minor link on intermediate loops, major link on the final one
   always_comb begin
      tgt_valid = 1'b0;
      tgt       = '0;
      if (fin && !eng_err) begin
         if (eng_last) begin
            tgt_valid = mj_en_v[start_ch_q];
            tgt       = mj_to_a[start_ch_q];
         end else begin
            tgt_valid = mn_en_v[start_ch_q];
            tgt       = mn_to_a[start_ch_q];
         end
      end
   end

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_slot
         chan_slot #(
            .NCH(NCH), .SRC_W(SRC_W), .ALWAYS_BASE(ALWAYS_BASE), .IDX(c)
         ) u_slot (
            .clk(clk), .rst_n(rst_n),
            .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ch(cmd_ch),
            .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_src(cfg_src), .cfg_en(cfg_en),
            .link_we(link_we), .link_ch(link_ch),
            .link_minor_en(link_minor_en), .link_minor_to(link_minor_to),
            .link_major_en(link_major_en), .link_major_to(link_major_to),
            .prio_we(prio_we), .prio_ch(prio_ch), .prio_lvl(prio_lvl),
            .hw_req(hw_req),
            .grant_me(grant && (win_ch == CH_W'(c))),
            .fin_me(fin && (start_ch_q == CH_W'(c))),
            .fin_last(eng_last), .fin_err(eng_err),
            .link_hit(tgt_valid && (tgt == CH_W'(c))),
            .eligible(elig_vec[c]), .lvl(lvl_arr[c]),
            .minor_en(mn_en_v[c]), .minor_to(mn_to_a[c]),
            .major_en(mj_en_v[c]), .major_to(mj_to_a[c]),
            .req_en(req_en_vec[c]), .done(done_vec[c]),
            .err(err_vec[c]), .irq(irq_vec[c])
         );
      end
   endgenerate

   prio_pick #(.NCH(NCH)) u_pick (
      .elig(elig_vec), .lvl(lvl_arr), .any(win_valid), .win(win_ch)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q        <= 1'b0;
         start_valid_q <= 1'b0;
         start_ch_q    <= '0;
      end else begin
         start_valid_q <= grant;
         if (grant) begin
            busy_q     <= 1'b1;
            start_ch_q <= win_ch;
         end else if (fin) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign start_valid = start_valid_q;
   assign start_ch    = start_ch_q;
   assign busy        = busy_q;

   // R11
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_valid_q |=> !start_valid_q);

   // R11
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_valid_q |-> busy_q);

   // R7
   pick_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> elig_vec[win_ch]);

   // R6
   major_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && eng_done && eng_last && !eng_err) |=> done_vec[$past(start_ch_q)]);

   // R9
   err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && eng_done && eng_err) |=> err_vec[$past(start_ch_q)]);

endmodule

// File: tb/tb_chan_start_ctl.sv
`timescale 1ns/1ps
module tb_chan_start_ctl;

   localparam int NCH = 16;
   localparam int CW  = 4;
   localparam int SW  = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 0; logic [2:0] cmd_op = 0; logic [CW-1:0] cmd_ch = 0;
   logic cfg_we = 0; logic [CW-1:0] cfg_ch = 0; logic [SW-1:0] cfg_src = 0; logic cfg_en = 0;
   logic link_we = 0; logic [CW-1:0] link_ch = 0;
   logic link_minor_en = 0; logic [CW-1:0] link_minor_to = 0;
   logic link_major_en = 0; logic [CW-1:0] link_major_to = 0;
   logic prio_we = 0; logic [CW-1:0] prio_ch = 0; logic [CW-1:0] prio_lvl = 0;
   logic [63:0] hw_req = '0;
   logic eng_done = 0, eng_last = 0, eng_err = 0;
   logic start_valid, busy;
   logic [CW-1:0] start_ch;
   logic [NCH-1:0] req_en_vec, done_vec, err_vec, irq_vec;

   int total = 0, fails = 0;
   bit ended = 0;

   always #5 clk = ~clk;

   chan_start_ctl dut (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ch(cmd_ch),
      .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_src(cfg_src), .cfg_en(cfg_en),
      .link_we(link_we), .link_ch(link_ch),
      .link_minor_en(link_minor_en), .link_minor_to(link_minor_to),
      .link_major_en(link_major_en), .link_major_to(link_major_to),
      .prio_we(prio_we), .prio_ch(prio_ch), .prio_lvl(prio_lvl),
      .hw_req(hw_req), .eng_done(eng_done), .eng_last(eng_last), .eng_err(eng_err),
      .start_valid(start_valid), .start_ch(start_ch), .busy(busy),
      .req_en_vec(req_en_vec), .done_vec(done_vec), .err_vec(err_vec), .irq_vec(irq_vec)
   );

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic report();
      if (!ended) begin
         ended = 1;
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   endtask

   task automatic cmd(input int op, input int ch);
      cmd_valid = 1; cmd_op = 3'(op); cmd_ch = CW'(ch);
      step();
      cmd_valid = 0;
   endtask

   task automatic cfg(input int ch, input int src, input bit en);
      cfg_we = 1; cfg_ch = CW'(ch); cfg_src = SW'(src); cfg_en = en;
      step();
      cfg_we = 0;
   endtask

   task automatic lnk(input int ch, input bit mn, input int mto, input bit mj, input int jto);
      link_we = 1; link_ch = CW'(ch);
      link_minor_en = mn; link_minor_to = CW'(mto);
      link_major_en = mj; link_major_to = CW'(jto);
      step();
      link_we = 0;
   endtask

   task automatic prio(input int ch, input int lv);
      prio_we = 1; prio_ch = CW'(ch); prio_lvl = CW'(lv);
      step();
      prio_we = 0;
   endtask

   task automatic fin(input bit last, input bit err);
      eng_done = 1; eng_last = last; eng_err = err;
      step();
      eng_done = 0; eng_last = 0; eng_err = 0;
   endtask

   task automatic expect_start(input string req, input int exp_ch, input int lim);
      int got = -1;
      for (int i = 0; i < lim; i++) begin
         step();
         if (start_valid) begin
            got = int'(start_ch);
            break;
         end
      end
      chk(req, got, exp_ch);
   endtask

   task automatic no_start(input string req, input int n);
      int seen = 0;
      for (int i = 0; i < n; i++) begin
         step();
         if (start_valid) seen++;
      end
      chk(req, seen, 0);
   endtask

   function automatic int pick(input logic [NCH-1:0] p, input int lv[NCH]);
      int best = -1;
      for (int c = 0; c < NCH; c++)
         if (p[c] && (best < 0 || lv[c] >= lv[best])) best = c;
      return best;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
   end

   initial begin
      int lv[NCH];
      logic [NCH-1:0] pend_m;
      bit busy_m;
      void'($urandom(32'd4242));
      repeat (3) step();
      rst_n = 1;
      step();

      // R1 reset state
      chk("R1 busy", int'(busy), 0);
      chk("R1 start", int'(start_valid), 0);
      chk("R1 gates", int'(req_en_vec), 0);
      chk("R1 status", int'(done_vec | err_vec | irq_vec), 0);

      // R4 software start ignores the gate and fires once
      cmd(2, 3);
      expect_start("R4 sw start", 3, 4);
      fin(0, 0);
      no_start("R4 single shot", 4);

      // R2 gating of hardware requests
      cfg(5, 7, 1);
      hw_req[7] = 1;
      no_start("R2 gate off", 4);
      cmd(0, 5);
      expect_start("R2 gate on", 5, 4);
      hw_req = '0;
      fin(0, 0);
      no_start("R2 line low", 3);
      cmd(1, 5);
      chk("R2 gate cleared", int'(req_en_vec[5]), 0);
      cfg(5, 7, 0);
      cmd(0, 5);
      hw_req[7] = 1;
      no_start("R2 trig off", 4);
      hw_req = '0;
      cmd(1, 5);
      cfg(5, 7, 1);

      // R10 source change while enabled is ignored
      cfg(5, 9, 1);
      cmd(0, 5);
      hw_req[9] = 1;
      no_start("R10 new src ignored", 4);
      hw_req = '0; hw_req[7] = 1;
      expect_start("R10 old src kept", 5, 3);
      hw_req = '0;
      fin(0, 0);
      cmd(1, 5);

      // R3 always-on source runs back to back
      cfg(2, 62, 1);
      cmd(0, 2);
      expect_start("R3 first", 2, 4);
      fin(0, 0);
      expect_start("R3 back to back", 2, 1);
      cmd(1, 2);
      fin(0, 0);
      no_start("R3 stopped", 4);

      // R5 minor link, skipped on final iteration
      lnk(1, 1, 6, 0, 0);
      cmd(2, 1);
      expect_start("R5 src ch", 1, 4);
      fin(0, 0);
      expect_start("R5 linked", 6, 3);
      fin(1, 0);
      cmd(2, 1);
      expect_start("R5 src again", 1, 4);
      fin(1, 0);
      no_start("R5 final no link", 4);
      chk("R6 done set", int'(done_vec[1]), 1);
      chk("R6 irq set", int'(irq_vec[1]), 1);

      // R6 major link
      lnk(1, 0, 0, 1, 0);
      cmd(2, 1);
      expect_start("R6 src", 1, 4);
      fin(1, 0);
      expect_start("R6 major linked", 0, 3);
      fin(1, 0);
      chk("R6 linked done", int'(done_vec[0]), 1);

      // R9 clear commands and error
      cmd(3, 1);
      chk("R9 irq cleared", int'(irq_vec[1]), 0);
      chk("R9 done kept", int'(done_vec[1]), 1);
      cmd(4, 1);
      chk("R9 done cleared", int'(done_vec[1]), 0);
      cmd(2, 4);
      expect_start("R9 err ch", 4, 4);
      fin(0, 1);
      chk("R9 err set", int'(err_vec[4]), 1);
      chk("R9 err no done", int'(done_vec[4]), 0);
      cmd(5, 4);
      chk("R9 err cleared", int'(err_vec), 0);

      // R7 / R8 priority among held starts
      lnk(1, 0, 0, 0, 0);
      cmd(2, 0);
      expect_start("R8 hold ch", 0, 4);
      cmd(2, 3); cmd(2, 10);
      fin(0, 0);
      expect_start("R7 default order", 10, 3);
      fin(0, 0);
      expect_start("R8 held served", 3, 3);
      fin(0, 0);
      prio(3, 15);
      cmd(2, 0);
      expect_start("R8 hold ch2", 0, 4);
      cmd(2, 3); cmd(2, 10);
      fin(0, 0);
      expect_start("R7 override", 3, 3);
      fin(0, 0);
      expect_start("R7 override next", 10, 3);
      fin(0, 0);
      prio(10, 15);
      cmd(2, 0);
      expect_start("R8 hold ch3", 0, 4);
      cmd(2, 3); cmd(2, 10);
      fin(0, 0);
      expect_start("R7 tie high num", 10, 3);
      fin(0, 0);
      expect_start("R7 tie second", 3, 3);
      fin(0, 0);

      // R8 restart of the active channel itself
      cmd(2, 7);
      expect_start("R8 self", 7, 4);
      cmd(2, 7);
      fin(0, 0);
      expect_start("R8 self again", 7, 3);
      fin(0, 0);
      no_start("R8 drained", 3);

      // random phase: R7 R8 R11 against a model
      for (int c = 0; c < NCH; c++) begin
         lv[c] = int'($urandom % NCH);
         prio(c, lv[c]);
      end
      pend_m = '0;
      busy_m = 0;
      for (int n = 0; n < 3000; n++) begin
         bit do_cmd, drv_done, gv;
         int ch, gch;
         do_cmd = ($urandom % 10) < 3;
         ch = int'($urandom % NCH);
         drv_done = busy_m && (($urandom % 10) < 4);
         cmd_valid = do_cmd; cmd_op = 3'd2; cmd_ch = CW'(ch);
         eng_done = drv_done;
         gv = !busy_m && (pend_m != '0);
         gch = gv ? pick(pend_m, lv) : 0;
         step();
         chk("R11 start pulse", int'(start_valid), int'(gv));
         if (gv) chk("R7 random winner", int'(start_ch), gch);
         if (gv) pend_m[gch] = 1'b0;
         if (do_cmd) pend_m[ch] = 1'b1;
         busy_m = busy_m ? !drv_done : gv;
      end
      cmd_valid = 0; eng_done = 0;
      report();
   end

endmodule